// File: doc/BRIEF.md
# Serial Shift and Normalize Unit

This unit shifts a 26-bit accumulator, either alone or joined with a 26-bit extension word, one bit position per clock. A single 10-bit control word sets up the operation when the operation is launched. The control word chooses single or double length, whether the accumulator's top (sign) bit moves or stays in place, rounding, overflow detection, direction and a 5-bit shift amount. A caller applies the operands and the control word together with a one-cycle start pulse. It then waits for a one-cycle done pulse, at which point the results are valid. The results stay on the outputs until the next operation completes.

An amount field of all ones does not request a fixed shift. It requests normalization instead. The operand moves until its leading (left) or trailing (right) position holds a 1, or until a cap of 25 steps is reached. The normalized accumulator comes out on the store output. The accumulator result is then replaced by the number of steps taken, zero-extended. This lets a floating-point routine keep the mantissa and the exponent adjustment from the same pass.

Top module: `shn_unit`

## Requirements
- R1: The field ctrl_i decodes as follows: bit 9 selects double length, bit 8 selects sign participation, bit 7 selects rounding, bit 6 enables overflow, bit 5 selects left (1) or right (0), and bits 4:0 give the amount. With single length and the sign participating, the 26-bit accumulator shifts by the amount as one field and zeros enter the vacated positions.
- R2: When bit 8 is clear, accumulator bit 25 keeps its value and only bits 24:0 shift. Zeros enter the vacated positions.
- R3: In double length, the accumulator (high) and the extension (low) shift as one operand, and bits cross between them. In single length, res_b_o returns b_i unchanged.
- R4: When rounding is selected on a right shift, the last bit shifted out is added at the operand's least significant position, and the carry wraps within the operand. On a left shift, rounding has no effect.
- R5: When overflow is enabled on a fixed left shift, ovf_o is 1 if any 1 leaves the top of the operand (bit 25, or bit 24 when the sign is held). In every other case ovf_o is 0.
- R6: An amount of 31 normalizes. A left normalize stops as soon as the top operand position (bit 25, or bit 24 when the sign is held) is 1. It may stop after zero steps.
- R7: A right normalize stops as soon as accumulator bit 0 is 1.
- R8: After a normalize, store_o holds the normalized accumulator and res_b_o holds the normalized extension. res_a_o holds the step count in its low 5 bits, with all other bits 0, and count_o equals that count.
- R9: A normalize performs at most 25 steps. An all-zero operand reports a count of 25.
- R10: A normalize never sets ovf_o, even when overflow is enabled.
- R11: For an operation that performs N steps, done_o rises after the (N+1)-th rising edge following the edge that samples start_i, and stays high for one cycle. For a fixed shift, count_o equals N and store_o equals res_a_o.
- R12: A start_i pulse during a running operation is ignored. The running operation completes with its own result, and no extra done_o follows.
- R13: While reset is asserted, done_o, ovf_o, count_o and all result words are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Launch pulse, sampled while idle |
| ctrl_i | input | 10 | Control word |
| a_i | input | 26 | Accumulator operand |
| b_i | input | 26 | Extension operand |
| done_o | output | 1 | One-cycle completion pulse |
| res_a_o | output | 26 | Accumulator result, or the normalize count |
| res_b_o | output | 26 | Extension result |
| store_o | output | 26 | Value to store: the shifted or normalized accumulator |
| count_o | output | 5 | Steps performed |
| ovf_o | output | 1 | Overflow flag |

## Verification
Every result appears at once, on the done pulse, which comes N+2 cycles after the cycle in which start_i was driven, where N is the number of steps. That count includes the load edge and the finishing edge. The driver records the cycle of its start and pushes a model result with that expected latency. The monitor samples on falling edges, pops an entry on each done pulse and compares both the values and the elapsed cycle count. This way, a result that arrives early or late fails even when its value is right. A done pulse that arrives with nothing queued, such as one caused by an ignored start, is reported as a failure.

// File: rtl/shn_pkg.sv
package shn_pkg;
  localparam int SHN_AMT_W = 5;
  localparam int SHN_CTL_W = 5 + SHN_AMT_W;

  typedef struct packed {
    logic                 dbl;    // operand spans accumulator and extension
    logic                 sgn;    // top accumulator bit moves with the rest
    logic                 rnd;    // add last bit shifted out (right only)
    logic                 ovfen;  // flag 1s lost off the top (fixed left only)
    logic                 left;   // direction
    logic [SHN_AMT_W-1:0] amt;    // step count, all ones means normalize
  } shn_ctl_t;

  function automatic shn_ctl_t shn_decode(input logic [SHN_CTL_W-1:0] raw);
    shn_ctl_t c;
    c.dbl   = raw[SHN_CTL_W-1];
    c.sgn   = raw[SHN_CTL_W-2];
    c.rnd   = raw[SHN_CTL_W-3];
    c.ovfen = raw[SHN_CTL_W-4];
    c.left  = raw[SHN_CTL_W-5];
    c.amt   = raw[SHN_AMT_W-1:0];
    return c;
  endfunction
endpackage

// File: rtl/shn_step.sv
module shn_step #(
  parameter int W = 26
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  input  logic         dbl_i,
  input  logic         sgn_i,
  input  logic         left_i,
  output logic [W-1:0] a_o,
  output logic [W-1:0] b_o,
  output logic         out_o
);
  logic fill_lo;

  assign fill_lo = dbl_i ? b_i[W-1] : 1'b0;

  always_comb begin
    a_o   = a_i;
    b_o   = b_i;
    out_o = 1'b0;
    if (left_i) begin
      out_o = sgn_i ? a_i[W-1] : a_i[W-2];
      if (sgn_i) a_o = {a_i[W-2:0], fill_lo};
      else       a_o = {a_i[W-1], a_i[W-3:0], fill_lo};
      if (dbl_i) b_o = {b_i[W-2:0], 1'b0};
    end else begin
      out_o = dbl_i ? b_i[0] : a_i[0];
      if (sgn_i) a_o = {1'b0, a_i[W-1:1]};
      else       a_o = {a_i[W-1], 1'b0, a_i[W-2:1]};
      if (dbl_i) b_o = {a_i[0], b_i[W-1:1]};
    end
  end
endmodule

// File: rtl/shn_round.sv
module shn_round #(
  parameter int W = 26
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  input  logic         dbl_i,
  input  logic         sgn_i,
  input  logic         inc_i,
  output logic [W-1:0] a_o,
  output logic [W-1:0] b_o
);
  localparam int DW = 2 * W;

  logic [DW-1:0] sum_dbl;
  logic [W-1:0]  sum_sgl;

  assign sum_dbl = {a_i, b_i} + {{(DW-1){1'b0}}, inc_i};
  assign sum_sgl = a_i + {{(W-1){1'b0}}, inc_i};

  always_comb begin
    if (dbl_i) begin
      a_o = sum_dbl[DW-1:W];
      b_o = sum_dbl[W-1:0];
    end else begin
      a_o = sum_sgl;
      b_o = b_i;
    end
    // a held sign absorbs no carry: the magnitude wraps instead
    if (!sgn_i) a_o[W-1] = a_i[W-1];
  end
endmodule

// File: rtl/shn_seq.sv
module shn_seq #(
  parameter int AMT_W = 5,
  parameter int LIMIT = 25
) (
  input  logic             clk,
  input  logic             rst_sn,
  input  logic             start_i,
  input  logic             float_i,
  input  logic             hit_i,
  input  logic [AMT_W-1:0] amt_i,
  output logic             load_o,
  output logic             shift_o,
  output logic             finish_o,
  output logic             run_o,
  output logic [AMT_W-1:0] cnt_o
);
  localparam logic [AMT_W-1:0] LIM = AMT_W'(LIMIT);

  logic             run_q, run_d;
  logic [AMT_W-1:0] cnt_q, cnt_d;
  logic             at_end;

  always_comb begin
    at_end   = float_i ? (hit_i || cnt_q == LIM) : (cnt_q == amt_i);
    load_o   = !run_q && start_i;
    finish_o = run_q && at_end;
    shift_o  = run_q && !at_end;
    run_d    = run_q;
    cnt_d    = cnt_q;
    if (load_o) begin
      run_d = 1'b1;
      cnt_d = '0;
    end else if (finish_o) begin
      run_d = 1'b0;
    end else if (shift_o) begin
      cnt_d = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_sn) begin
    if (!rst_sn) begin
      run_q <= 1'b0;
      cnt_q <= '0;
    end else begin
      run_q <= run_d;
      cnt_q <= cnt_d;
    end
  end

  assign run_o = run_q;
  assign cnt_o = cnt_q;

  // R9: a normalize never runs past its step cap
  p_float_limit_r9: assert property (@(posedge clk) disable iff (!rst_sn)
    (run_q && float_i) |-> (cnt_q <= LIM));
endmodule

// File: rtl/shn_unit.sv
module shn_unit #(
  parameter int W     = 26,
  parameter int LIMIT = W - 1
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         start_i,
  input  logic [shn_pkg::SHN_CTL_W-1:0] ctrl_i,
  input  logic [W-1:0]                 a_i,
  input  logic [W-1:0]                 b_i,
  output logic                         done_o,
  output logic [W-1:0]                 res_a_o,
  output logic [W-1:0]                 res_b_o,
  output logic [W-1:0]                 store_o,
  output logic [shn_pkg::SHN_AMT_W-1:0] count_o,
  output logic                         ovf_o
);
  import shn_pkg::*;
  localparam int AW = SHN_AMT_W;

  logic rs0_q, rst_sn;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) {rst_sn, rs0_q} <= 2'b00;
    else        {rst_sn, rs0_q} <= {rs0_q, 1'b1};
  end

  shn_ctl_t       ctl_q, ctl_d;
  logic [W-1:0]   wa_q, wa_d, wb_q, wb_d;
  logic           last_q, last_d, ovf_q, ovf_d;
  logic [W-1:0]   ra_d, rb_d, st_d;
  logic [AW-1:0]  cnt_res_d;
  logic           ovf_res_d;
  logic           is_float, hit, load, shift, finish, run;
  logic [AW-1:0]  cnt;
  logic [W-1:0]   sa, sb, rda, rdb;
  logic           sout;

  assign is_float = &ctl_q.amt;
  assign hit = ctl_q.left ? (ctl_q.sgn ? wa_q[W-1] : wa_q[W-2]) : wa_q[0];

  shn_seq #(.AMT_W(AW), .LIMIT(LIMIT)) u_seq (
    .clk(clk), .rst_sn(rst_sn), .start_i(start_i), .float_i(is_float),
    .hit_i(hit), .amt_i(ctl_q.amt), .load_o(load), .shift_o(shift),
    .finish_o(finish), .run_o(run), .cnt_o(cnt));

  shn_step #(.W(W)) u_step (
    .a_i(wa_q), .b_i(wb_q), .dbl_i(ctl_q.dbl), .sgn_i(ctl_q.sgn),
    .left_i(ctl_q.left), .a_o(sa), .b_o(sb), .out_o(sout));

  shn_round #(.W(W)) u_round (
    .a_i(wa_q), .b_i(wb_q), .dbl_i(ctl_q.dbl), .sgn_i(ctl_q.sgn),
    .inc_i(ctl_q.rnd && !ctl_q.left && last_q), .a_o(rda), .b_o(rdb));

  always_comb begin
    ctl_d     = ctl_q;
    wa_d      = wa_q;
    wb_d      = wb_q;
    last_d    = last_q;
    ovf_d     = ovf_q;
    ra_d      = res_a_o;
    rb_d      = res_b_o;
    st_d      = store_o;
    cnt_res_d = count_o;
    ovf_res_d = ovf_o;
    if (load) begin
      ctl_d  = shn_decode(ctrl_i);
      wa_d   = a_i;
      wb_d   = b_i;
      last_d = 1'b0;
      ovf_d  = 1'b0;
    end else if (shift) begin
      wa_d   = sa;
      wb_d   = sb;
      last_d = sout;
      if (ctl_q.left && ctl_q.ovfen && !is_float) ovf_d = ovf_q | sout;
    end
    if (finish) begin
      st_d      = rda;
      rb_d      = rdb;
      ra_d      = is_float ? {{(W-AW){1'b0}}, cnt} : rda;
      cnt_res_d = cnt;
      ovf_res_d = ovf_q;
    end
  end

  always_ff @(posedge clk or negedge rst_sn) begin
    if (!rst_sn) begin
      ctl_q   <= '0;
      wa_q    <= '0;
      wb_q    <= '0;
      last_q  <= 1'b0;
      ovf_q   <= 1'b0;
      done_o  <= 1'b0;
      res_a_o <= '0;
      res_b_o <= '0;
      store_o <= '0;
      count_o <= '0;
      ovf_o   <= 1'b0;
    end else begin
      ctl_q   <= ctl_d;
      wa_q    <= wa_d;
      wb_q    <= wb_d;
      last_q  <= last_d;
      ovf_q   <= ovf_d;
      done_o  <= finish;
      res_a_o <= ra_d;
      res_b_o <= rb_d;
      store_o <= st_d;
      count_o <= cnt_res_d;
      ovf_o   <= ovf_res_d;
    end
  end

  // R11: completion is a single-cycle pulse
  p_done_pulse_r11: assert property (@(posedge clk) disable iff (!rst_sn)
    done_o |=> !done_o);
  // R2: a held sign survives every step
  p_sign_hold_r2: assert property (@(posedge clk) disable iff (!rst_sn)
    (shift && !ctl_q.sgn) |=> (wa_q[W-1] == $past(wa_q[W-1])));
  // R5: right shifts never report overflow
  p_no_ovf_right_r5: assert property (@(posedge clk) disable iff (!rst_sn)
    (done_o && !ctl_q.left) |-> !ovf_o);
  // R10: normalize never reports overflow
  p_float_no_ovf_r10: assert property (@(posedge clk) disable iff (!rst_sn)
    (done_o && is_float) |-> !ovf_o);
  // R8: normalize replaces the accumulator result with the count
  p_float_count_r8: assert property (@(posedge clk) disable iff (!rst_sn)
    (done_o && is_float) |-> (res_a_o[W-1:AW] == '0 && res_a_o[AW-1:0] == count_o));
  // R12: a start while running leaves the captured setup alone
  p_busy_ignore_r12: assert property (@(posedge clk) disable iff (!rst_sn)
    (run && start_i) |=> $stable(ctl_q));
endmodule

// File: tb/shn_unit_tb.sv
module shn_unit_tb;
  localparam int CLK_PERIOD = 10;
  localparam int W = 26;

  logic          clk = 1'b0;
  logic          rst_n, start_i;
  logic [9:0]    ctrl_i;
  logic [W-1:0]  a_i, b_i;
  logic          done_o, ovf_o;
  logic [W-1:0]  res_a_o, res_b_o, store_o;
  logic [4:0]    count_o;

  shn_unit u_dut (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .ctrl_i(ctrl_i),
    .a_i(a_i), .b_i(b_i), .done_o(done_o), .res_a_o(res_a_o),
    .res_b_o(res_b_o), .store_o(store_o), .count_o(count_o), .ovf_o(ovf_o));

  always #(CLK_PERIOD/2) clk = ~clk;

  typedef struct {
    logic [W-1:0] ra, rb, st;
    logic [4:0]   cnt;
    logic         ovf;
    int           lat;
    string        req;
  } exp_t;

  exp_t q[$];
  int   n_chk = 0, n_fail = 0;
  int   cyc = 0, start_cyc = 0;
  bit   live = 1'b0, ended = 1'b0;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic logic [9:0] mk(bit dbl, bit sgn, bit rnd, bit oen,
                                    bit lft, int amt);
    return {dbl, sgn, rnd, oen, lft, 5'(amt)};
  endfunction

  function automatic exp_t model(logic [9:0] c, logic [W-1:0] a,
                                 logic [W-1:0] b, string req);
    exp_t e;
    logic [51:0] op, mask;
    logic [W-1:0] ea, eb;
    bit dbl, sgn, rnd, oen, lft, flt, last, ov, stop;
    int n, k;
    dbl = c[9]; sgn = c[8]; rnd = c[7]; oen = c[6]; lft = c[5];
    flt = (c[4:0] == 5'd31);
    n = (dbl ? 52 : 26) - (sgn ? 0 : 1);
    mask = (52'd1 << n) - 52'd1;
    op = (dbl ? {a, b} : {26'd0, a}) & mask;
    k = 0; last = 0; ov = 0;
    for (int i = 0; i < 64; i++) begin
      if (flt) stop = (lft ? op[n-1] : (dbl ? op[26] : op[0])) || (k == 25);
      else     stop = (k == int'(c[4:0]));
      if (stop) break;
      if (lft) begin
        last = op[n-1];
        op = (op << 1) & mask;
        if (oen && !flt) ov = ov | last;
      end else begin
        last = op[0];
        op = op >> 1;
      end
      k++;
    end
    if (rnd && !lft) op = (op + {51'd0, last}) & mask;
    if (dbl) begin ea = op[51:26]; eb = op[25:0]; end
    else     begin ea = op[25:0];  eb = b;         end
    if (!sgn) ea[W-1] = a[W-1];
    e.st = ea; e.rb = eb; e.ra = flt ? W'(k) : ea;
    e.cnt = 5'(k); e.ovf = ov; e.lat = k + 2; e.req = req;
    return e;
  endfunction

  task automatic launch(input logic [9:0] c, input logic [W-1:0] a,
                        input logic [W-1:0] b);
    @(negedge clk);
    start_i = 1'b1; ctrl_i = c; a_i = a; b_i = b;
    start_cyc = cyc;
    @(negedge clk);
    start_i = 1'b0;
  endtask

  task automatic run_op(input logic [9:0] c, input logic [W-1:0] a,
                        input logic [W-1:0] b, input string req);
    q.push_back(model(c, a, b, req));
    launch(c, a, b);
    while (q.size() != 0) @(negedge clk);
  endtask

  // scoreboard monitor
  always @(negedge clk) begin
    if (live && done_o) begin
      if (q.size() == 0) begin
        n_chk++; n_fail++;
        $display("FAIL R12 unexpected done actual=1 expected=0");
      end else begin
        exp_t e;
        e = q.pop_front();
        chk(e.req, "res_a", 32'(res_a_o), 32'(e.ra));
        chk(e.req, "res_b", 32'(res_b_o), 32'(e.rb));
        chk(e.req, "store", 32'(store_o), 32'(e.st));
        chk(e.req, "count", 32'(count_o), 32'(e.cnt));
        chk(e.req, "ovf",   32'(ovf_o),   32'(e.ovf));
        chk({e.req, " R11"}, "latency", 32'(cyc - start_cyc), 32'(e.lat));
      end
    end
  end

  task automatic finish_run();
    if (!ended) begin
      ended = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired actual=running expected=finished");
    finish_run();
  end

  initial begin
    rst_n = 1'b0; start_i = 1'b0; ctrl_i = '0; a_i = '0; b_i = '0;
    repeat (4) @(negedge clk);
    chk("R13", "reset done",  32'(done_o),  0);
    chk("R13", "reset ovf",   32'(ovf_o),   0);
    chk("R13", "reset count", 32'(count_o), 0);
    chk("R13", "reset res_a", 32'(res_a_o), 0);
    chk("R13", "reset res_b", 32'(res_b_o), 0);
    chk("R13", "reset store", 32'(store_o), 0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    live = 1'b1;

    // R1 fixed single-length shifts with sign moving
    run_op(mk(0,1,0,0,1,3),  26'h0123456, 26'h1555555, "R1");
    run_op(mk(0,1,0,0,0,5),  26'h2ABCDEF, 26'h0000001, "R1");
    run_op(mk(0,1,0,0,1,0),  26'h3000001, 26'h0, "R1 R11");
    // R2 held sign
    run_op(mk(0,0,0,0,1,4),  26'h2F0F0F1, 26'h0, "R2");
    run_op(mk(0,0,0,0,0,7),  26'h3C00F0F, 26'h0, "R2");
    // R3 double length
    run_op(mk(1,1,0,0,1,10), 26'h0012345, 26'h3ABCDEF, "R3");
    run_op(mk(1,0,0,0,0,20), 26'h2FEDCBA, 26'h1234567, "R3");
    run_op(mk(1,1,0,0,1,30), 26'h0000007, 26'h3FFFFFF, "R3");
    // R4 rounding
    run_op(mk(0,1,1,0,0,3),  26'h0000005, 26'h0, "R4");
    run_op(mk(1,1,1,0,0,4),  26'h0000001, 26'h3FFFFF8, "R4");
    run_op(mk(0,0,1,0,0,1),  26'h3FFFFFF, 26'h0, "R4");
    run_op(mk(0,1,1,0,1,2),  26'h0000003, 26'h0, "R4");
    // R5 overflow
    run_op(mk(0,1,0,1,1,4),  26'h0800000, 26'h0, "R5");
    run_op(mk(0,1,0,0,1,4),  26'h0800000, 26'h0, "R5");
    run_op(mk(0,0,0,1,1,2),  26'h2000000, 26'h0, "R5");
    run_op(mk(0,0,0,1,1,2),  26'h0800000, 26'h0, "R5");
    run_op(mk(0,1,0,1,0,6),  26'h3FFFFFF, 26'h0, "R5");
    // R6 left normalize
    run_op(mk(0,1,0,0,1,31), 26'h0000400, 26'h0, "R6 R8");
    run_op(mk(0,0,0,0,1,31), 26'h2000003, 26'h0, "R6 R8");
    run_op(mk(0,1,0,0,1,31), 26'h2000000, 26'h0, "R6");
    run_op(mk(1,1,0,0,1,31), 26'h0000000, 26'h0ABCDEF, "R6 R8");
    // R7 right normalize
    run_op(mk(0,1,0,0,0,31), 26'h0001000, 26'h0, "R7 R8");
    run_op(mk(1,0,0,0,0,31), 26'h2000300, 26'h0000055, "R7 R8");
    // R9 all-zero normalize caps at 25
    run_op(mk(0,1,0,0,1,31), 26'h0, 26'h0, "R9");
    chk("R9", "zero float res_a", 32'(res_a_o), 32'd25);
    // R10 normalize with overflow enabled
    run_op(mk(0,1,0,1,1,31), 26'h0000010, 26'h0, "R10");
    // R12 start while busy is ignored
    q.push_back(model(mk(0,1,0,0,1,8), 26'h0000F0F, 26'h0, "R12"));
    launch(mk(0,1,0,0,1,8), 26'h0000F0F, 26'h0);
    @(negedge clk);
    start_i = 1'b1; ctrl_i = mk(1,0,1,1,0,2); a_i = 26'h3FFFFFF; b_i = 26'h3FFFFFF;
    @(negedge clk);
    start_i = 1'b0;
    while (q.size() != 0) @(negedge clk);
    repeat (20) @(negedge clk);
    run_op(mk(0,1,0,0,0,2),  26'h0000008, 26'h0, "R12");

    repeat (3) @(negedge clk);
    chk("R11", "queue drained", 32'(q.size()), 0);
    finish_run();
  end
endmodule